// File: doc/BRIEF.md
# ADC Channel Selection Shadow Controller

This block sits between processor-written selection registers and an analog converter core. Software writes a six-bit channel code as two fields in two registers: a single high bit and a five-bit low field. It also writes a reference selection. The block keeps these values in holding buffers. It passes them to the active selection that drives the analog multiplexer only at moments when a change cannot disturb a conversion.

While no conversion is running, the active channel follows the holding buffer. A start request, or an external trigger event while automatic mode is on, freezes the active selection. The selection stays frozen until the core reports that the conversion is complete. Whenever the active channel moves while the converter is enabled, a settling window of `SETTLE_CYC` cycles is inserted. Sampling is not granted until that window ends. A start that arrives inside the window is held and granted afterwards. The active reference changes only when the converter is switched off and then back on.

Top module: `adc_sel_shadow`

## Requirements
- R1: After reset the active channel is 0, the active reference is 0, the settling flag and the sampling grant are low, and no conversion is locked.
- R2: A write to the low field loads the channel buffer with {stored high bit, low field}, where the high bit is bit 5 and the low field is bits 4:0. While no conversion is locked, the active channel takes the buffered code one cycle after the buffer changes.
- R3: A write to the high bit alone changes neither the channel buffer nor the active channel until a low-field write follows.
- R4: While enabled and unlocked, a start request, or a trigger event while automatic mode is on, locks the selection. Channel writes made while locked do not change the active channel.
- R5: The conversion-complete pulse releases the lock. The channel buffered during the conversion then becomes active one cycle later.
- R6: The active reference loads the reference buffer only in the cycle in which enable goes from low to high. It stays unchanged while the converter stays enabled.
- R7: A change of the active channel while enabled raises the settling flag for exactly `SETTLE_CYC` cycles. A change while disabled raises no settling.
- R8: A start accepted with no settling in progress produces a one-cycle sampling grant in the following cycle.
- R9: A start accepted during settling is queued. Its grant comes one cycle after the settling flag falls, and a grant never appears while the flag is high.
- R10: Start requests are ignored while disabled, and trigger events are ignored while automatic mode is off. In both cases no grant is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_hi_i | input | 1 | Write strobe for the channel high bit |
| wr_hi_data_i | input | HI_W | High-bit write data |
| wr_lo_i | input | 1 | Write strobe for the channel low field, which commits the buffer |
| wr_lo_data_i | input | LO_W | Low-field write data |
| wr_ref_i | input | 1 | Write strobe for the reference buffer |
| wr_ref_data_i | input | REF_W | Reference write data |
| en_i | input | 1 | Converter enable |
| start_i | input | 1 | Software start request |
| auto_en_i | input | 1 | Automatic trigger mode |
| trig_i | input | 1 | Trigger event pulse |
| done_i | input | 1 | Conversion-complete pulse from the core |
| act_chan_o | output | LO_W+HI_W | Active channel selection |
| act_ref_o | output | REF_W | Active reference selection |
| settle_busy_o | output | 1 | Settling window in progress |
| sample_grant_o | output | 1 | One-cycle permission to start sampling |

## Verification
A table of channel codes is written while the converter is disabled. The codes set and clear the high bit and the low-field bits independently, so that a field mixed up with the other, or a stale high bit, shows up as a wrong active code. Directed sequences then separate the cases that a plain pass-through would blur:
- a high-bit write with no low write after it;
- a write during a locked conversion compared with one after completion;
- a start on a quiet channel compared with a start inside the settling window, where the gap between the flag falling and the grant is counted;
- a reference write seen across a disable and re-enable;
- trigger events with automatic mode on and off.

// File: rtl/adc_sel_pkg.sv
package adc_sel_pkg;
   localparam int CHAN_LO_W  = 5;
   localparam int CHAN_HI_W  = 1;
   localparam int REF_SEL_W  = 2;
   localparam int SETTLE_DEF = 16;

   // how the active reference picks up the buffered value
   typedef enum logic {
      REF_ON_RISE = 1'b1,   // load only as enable rises
      REF_WHILE_OFF = 1'b0  // follow buffer whenever disabled
   } ref_mode_e;
endpackage

// File: rtl/adc_sel_buffer.sv
module adc_sel_buffer #(
   parameter int LO_W  = adc_sel_pkg::CHAN_LO_W,
   parameter int HI_W  = adc_sel_pkg::CHAN_HI_W,
   parameter int REF_W = adc_sel_pkg::REF_SEL_W,
   localparam int CH_W = LO_W + HI_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hi_i,
   input  logic [HI_W-1:0]  wr_hi_data_i,
   input  logic             wr_lo_i,
   input  logic [LO_W-1:0]  wr_lo_data_i,
   input  logic             wr_ref_i,
   input  logic [REF_W-1:0] wr_ref_data_i,
   output logic [CH_W-1:0]  chan_buf_o,
   output logic [REF_W-1:0] ref_buf_o
);
   logic [HI_W-1:0] hi_q;

   if (LO_W < 1 || HI_W < 1) begin : g_bad_chan
      $error("adc_sel_buffer: channel fields need at least one bit");
   end
   if (REF_W < 1) begin : g_bad_ref
      $error("adc_sel_buffer: reference field needs at least one bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q       <= '0;
         chan_buf_o <= '0;
         ref_buf_o  <= '0;
      end else begin
         if (wr_hi_i)  hi_q       <= wr_hi_data_i;
         if (wr_lo_i)  chan_buf_o <= {hi_q, wr_lo_data_i};
         if (wr_ref_i) ref_buf_o  <= wr_ref_data_i;
      end
   end

   // R3
   buf_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lo_i |=> $stable(chan_buf_o));
endmodule

// File: rtl/adc_sel_active.sv
module adc_sel_active #(
   parameter int CH_W  = adc_sel_pkg::CHAN_LO_W + adc_sel_pkg::CHAN_HI_W,
   parameter int REF_W = adc_sel_pkg::REF_SEL_W,
   parameter adc_sel_pkg::ref_mode_e REF_MODE = adc_sel_pkg::REF_ON_RISE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             lock_i,
   input  logic [CH_W-1:0]  chan_buf_i,
   input  logic [REF_W-1:0] ref_buf_i,
   output logic [CH_W-1:0]  act_chan_o,
   output logic [REF_W-1:0] act_ref_o,
   output logic             chan_chg_o
);
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         act_chan_o <= '0;
      end else begin
         en_q <= en_i;
         if (!lock_i) act_chan_o <= chan_buf_i;
      end
   end

   if (REF_MODE == adc_sel_pkg::REF_ON_RISE) begin : g_ref_rise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             act_ref_o <= '0;
         else if (en_i && !en_q) act_ref_o <= ref_buf_i;
      end
   end else begin : g_ref_off
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     act_ref_o <= '0;
         else if (!en_i) act_ref_o <= ref_buf_i;
      end
   end

   assign chan_chg_o = en_i && !lock_i && (chan_buf_i != act_chan_o);

   // R4
   chan_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> $stable(act_chan_o));
   // R6
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && en_q) |=> $stable(act_ref_o));
endmodule

// File: rtl/adc_sel_settle.sv
module adc_sel_settle #(
   parameter int SETTLE_CYC = adc_sel_pkg::SETTLE_DEF,
   localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic load_i,
   output logic busy_o
);
   logic [CNT_W-1:0] cnt_q;

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("adc_sel_settle: SETTLE_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!en_i)          cnt_q <= '0;
      else if (load_i)         cnt_q <= CNT_W'(SETTLE_CYC);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign busy_o = (cnt_q != '0);

   // R7
   settle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(SETTLE_CYC));
endmodule

// File: rtl/adc_sel_seq.sv
module adc_sel_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic start_i,
   input  logic auto_en_i,
   input  logic trig_i,
   input  logic done_i,
   input  logic settle_busy_i,
   input  logic settle_load_i,
   output logic lock_o,
   output logic grant_o
);
   logic pend_q;
   logic go;
   logic want;

   assign go   = en_i && !lock_o && (start_i || (auto_en_i && trig_i));
   assign want = go || (pend_q && en_i && !done_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_o  <= 1'b0;
         pend_q  <= 1'b0;
         grant_o <= 1'b0;
      end else begin
         grant_o <= 1'b0;
         if (!en_i) begin
            lock_o <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            if (go)          lock_o <= 1'b1;
            else if (done_i) lock_o <= 1'b0;
            if (want && !settle_busy_i && !settle_load_i) begin
               grant_o <= 1'b1;
               pend_q  <= 1'b0;
            end else begin
               pend_q  <= want;
            end
         end
      end
   end

   // R8
   grant_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> lock_o);
   // R9
   grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> !settle_busy_i);
   // R8
   grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |=> !grant_o);
endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow #(
   parameter int LO_W       = adc_sel_pkg::CHAN_LO_W,
   parameter int HI_W       = adc_sel_pkg::CHAN_HI_W,
   parameter int REF_W      = adc_sel_pkg::REF_SEL_W,
   parameter int SETTLE_CYC = adc_sel_pkg::SETTLE_DEF,
   parameter adc_sel_pkg::ref_mode_e REF_MODE = adc_sel_pkg::REF_ON_RISE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_hi_i,
   input  logic [HI_W-1:0]      wr_hi_data_i,
   input  logic                 wr_lo_i,
   input  logic [LO_W-1:0]      wr_lo_data_i,
   input  logic                 wr_ref_i,
   input  logic [REF_W-1:0]     wr_ref_data_i,
   input  logic                 en_i,
   input  logic                 start_i,
   input  logic                 auto_en_i,
   input  logic                 trig_i,
   input  logic                 done_i,
   output logic [LO_W+HI_W-1:0] act_chan_o,
   output logic [REF_W-1:0]     act_ref_o,
   output logic                 settle_busy_o,
   output logic                 sample_grant_o
);
   localparam int CH_W = LO_W + HI_W;

   logic [CH_W-1:0]  chan_buf;
   logic [REF_W-1:0] ref_buf;
   logic             lock;
   logic             chan_chg;

   adc_sel_buffer #(.LO_W(LO_W), .HI_W(HI_W), .REF_W(REF_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_hi_i(wr_hi_i), .wr_hi_data_i(wr_hi_data_i),
      .wr_lo_i(wr_lo_i), .wr_lo_data_i(wr_lo_data_i),
      .wr_ref_i(wr_ref_i), .wr_ref_data_i(wr_ref_data_i),
      .chan_buf_o(chan_buf), .ref_buf_o(ref_buf)
   );

   adc_sel_active #(.CH_W(CH_W), .REF_W(REF_W), .REF_MODE(REF_MODE)) u_act (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .lock_i(lock),
      .chan_buf_i(chan_buf), .ref_buf_i(ref_buf),
      .act_chan_o(act_chan_o), .act_ref_o(act_ref_o), .chan_chg_o(chan_chg)
   );

   adc_sel_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .load_i(chan_chg),
      .busy_o(settle_busy_o)
   );

   adc_sel_seq u_seq (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i),
      .auto_en_i(auto_en_i), .trig_i(trig_i), .done_i(done_i),
      .settle_busy_i(settle_busy_o), .settle_load_i(chan_chg),
      .lock_o(lock), .grant_o(sample_grant_o)
   );

   // R7
   settle_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_i) && !$stable(act_chan_o)) |-> settle_busy_o);
   // R10
   no_grant_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_i) |-> !sample_grant_o);
endmodule

// File: tb/adc_sel_shadow_tb.sv
module adc_sel_shadow_tb;
   localparam int SETTLE = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_hi = 1'b0;
   logic [0:0] wr_hi_data = '0;
   logic       wr_lo = 1'b0;
   logic [4:0] wr_lo_data = '0;
   logic       wr_ref = 1'b0;
   logic [1:0] wr_ref_data = '0;
   logic       en = 1'b0, start = 1'b0, auto_en = 1'b0, trig = 1'b0, done = 1'b0;
   logic [5:0] act_chan;
   logic [1:0] act_ref;
   logic       busy, grant;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   adc_sel_shadow #(.SETTLE_CYC(SETTLE)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_hi_i(wr_hi), .wr_hi_data_i(wr_hi_data),
      .wr_lo_i(wr_lo), .wr_lo_data_i(wr_lo_data),
      .wr_ref_i(wr_ref), .wr_ref_data_i(wr_ref_data),
      .en_i(en), .start_i(start), .auto_en_i(auto_en), .trig_i(trig), .done_i(done),
      .act_chan_o(act_chan), .act_ref_o(act_ref),
      .settle_busy_o(busy), .sample_grant_o(grant)
   );

   // {high bit, low field, expected active code}
   localparam logic [11:0] VEC [8] = '{
      {1'b0, 5'h01, 6'h01}, {1'b1, 5'h00, 6'h20}, {1'b1, 5'h1F, 6'h3F},
      {1'b0, 5'h15, 6'h15}, {1'b1, 5'h0A, 6'h2A}, {1'b0, 5'h1E, 6'h1E},
      {1'b1, 5'h11, 6'h31}, {1'b0, 5'h03, 6'h03}
   };

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_chan(input logic h, input logic [4:0] l);
      wr_hi = 1'b1; wr_hi_data = h; cyc(1); wr_hi = 1'b0;
      wr_lo = 1'b1; wr_lo_data = l; cyc(1); wr_lo = 1'b0;
   endtask

   task automatic pulse_start();
      start = 1'b1; cyc(1); start = 1'b0;
   endtask

   task automatic pulse_done();
      done = 1'b1; cyc(1); done = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n;
      int quiet;
      bit seen_busy_grant;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 chan", act_chan, 0);
      chk("R1 ref", act_ref, 0);
      chk("R1 busy", busy, 0);
      chk("R1 grant", grant, 0);

      // table walk, converter disabled
      for (int i = 0; i < 8; i++) begin
         wr_chan(VEC[i][11], VEC[i][10:6]);
         cyc(1);
         chk("R2 table chan", act_chan, int'(VEC[i][5:0]));
         chk("R7 no settle while off", busy, 0);
      end

      // high bit alone
      wr_hi = 1'b1; wr_hi_data = 1'b1; cyc(1); wr_hi = 1'b0;
      cyc(2);
      chk("R3 high only", act_chan, 6'h03);
      wr_lo = 1'b1; wr_lo_data = 5'h04; cyc(1); wr_lo = 1'b0;
      cyc(1);
      chk("R2 stored high bit", act_chan, 6'h24);

      // settle length
      en = 1'b1; cyc(2);
      wr_chan(1'b0, 5'h07);
      cyc(1);
      chk("R2 enabled chan", act_chan, 6'h07);
      n = 0;
      seen_busy_grant = 0;
      while (busy && n < 100) begin
         n++;
         if (grant) seen_busy_grant = 1;
         cyc(1);
      end
      chk("R7 settle length", n, SETTLE);
      chk("R9 no grant in settle", seen_busy_grant, 0);

      // idle start
      pulse_start();
      chk("R8 immediate grant", grant, 1);
      cyc(1);
      chk("R8 grant single", grant, 0);

      // write while locked
      wr_chan(1'b1, 5'h09);
      cyc(3);
      chk("R4 locked chan", act_chan, 6'h07);
      pulse_done();
      chk("R5 chan at done", act_chan, 6'h07);
      cyc(1);
      chk("R5 chan after done", act_chan, 6'h29);
      chk("R7 settle after done", busy, 1);

      // queued start
      pulse_start();
      chk("R9 no grant while settling", grant, 0);
      n = 0; quiet = 0; seen_busy_grant = 0;
      while (!grant && n < 100) begin
         cyc(1);
         n++;
         if (!busy && !grant) quiet++;
         if (busy && grant) seen_busy_grant = 1;
      end
      chk("R9 queued grant seen", grant, 1);
      chk("R9 grant gap", quiet, 1);
      chk("R9 grant not busy", seen_busy_grant, 0);
      pulse_done();
      cyc(2);

      // reference
      wr_ref = 1'b1; wr_ref_data = 2'd2; cyc(1); wr_ref = 1'b0;
      cyc(3);
      chk("R6 ref held enabled", act_ref, 0);
      en = 1'b0; cyc(1);
      chk("R6 ref held off", act_ref, 0);
      en = 1'b1; cyc(1);
      chk("R6 ref on re-enable", act_ref, 2);
      cyc(2);

      // trigger
      trig = 1'b1; cyc(1); trig = 1'b0;
      chk("R10 trigger manual mode", grant, 0);
      auto_en = 1'b1;
      trig = 1'b1; cyc(1); trig = 1'b0;
      chk("R4 trigger auto mode", grant, 1);
      wr_chan(1'b0, 5'h02);
      cyc(2);
      chk("R4 trigger locks", act_chan, 6'h29);
      pulse_done();
      auto_en = 1'b0;
      cyc(SETTLE + 4);

      // disabled start
      en = 1'b0; cyc(1);
      pulse_start();
      chk("R10 start while off", grant, 0);
      wr_chan(1'b1, 5'h01);
      cyc(1);
      chk("R2 off chan", act_chan, 6'h21);
      chk("R7 off no settle", busy, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule